// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block sits in the read path of a parallel NOR-style flash device. It decides what a read cycle returns while an internal byte program or an erase (sector, block or whole array) is running. When the device is idle the block passes the array data through unchanged. When it is busy, every read returns a status byte. The top bit of that byte is a completion flag: it is the complement of the top bit of the byte being programmed, or zero during an erase. The next bit is a toggle that flips once for each completed read cycle.

A host polls either bit until it stops reporting busy, then reads real data. The busy flag and the operation type come from the internal timing generator. They are registered on entry, so the reported state changes only on a clock edge. The program byte is captured when the operation starts. The read strobe is the decoded chip-enable/output-enable read cycle, and its rising edge marks one read.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, with `busy_i` low, `rd_data_o` equals `array_data_i` on all eight bits.
- R2: While a program (`op_erase_i` = 0 at start) is active, `rd_data_o[7]` is the inverse of bit 7 of `last_data_i` as sampled on the cycle the operation started. Later changes of `last_data_i` have no effect until the next start.
- R3: While an erase (`op_erase_i` = 1 at start) is active, `rd_data_o[7]` is 0.
- R4: While active, `rd_data_o[6]` inverts once on the clock edge that first samples `rd_strobe_i` high after it was low. The first read after a start therefore returns 1, and later reads alternate.
- R5: While active, `rd_data_o[5:0]` is 0.
- R6: One clock edge after `busy_i` falls, `rd_data_o` returns the full `array_data_i`. For example, an erased location reads FFh, so bit 7 is 1.
- R7: A change of `busy_i` is not visible at `rd_data_o` until the next rising clock edge.
- R8: Holding `rd_strobe_i` high for several cycles counts as a single read, and the toggle bit does not change again.
- R9: The toggle bit is cleared to 0 on the edge that starts a new operation, whatever its value at the end of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Internal program/erase in progress |
| op_erase_i | input | 1 | Operation kind at start: 1 erase, 0 program |
| last_data_i | input | 8 | Byte being programmed |
| rd_strobe_i | input | 1 | High during a host read cycle |
| array_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Byte returned to the host |

## Verification
Suppose the captured program byte or the operation kind were wrong. The fault would appear at bit 7 on the first status read after the start edge. A toggle flop that misses an edge, double-counts a held strobe, or is not cleared at a new start would give a wrong bit 6 at the next read. A wrong activity register would show one cycle early or late as array data in place of status, or status in place of array data, at the busy transitions. Because the bench checks every read and every transition edge, each such fault is caught within one read cycle.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int WORD_W     = 8;
    localparam int POLL_POS   = 7;
    localparam int TOGGLE_POS = 6;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic              active;
        op_kind_e          kind;
        logic [WORD_W-1:0] wdata;
    } op_state_t;

    // Completion flag reported on the poll bit while an operation runs
    function automatic logic poll_flag(op_state_t st);
        if (st.kind == OP_ERASE) return 1'b0;
        return ~st.wdata[POLL_POS];
    endfunction

endpackage

// File: rtl/fsr_op_tracker.sv
module fsr_op_tracker
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              kind_i,
    input  logic [WORD_W-1:0] wdata_i,
    output op_state_t         state_o,
    output logic              start_o
);

    op_state_t st_q;

    assign start_o = busy_i && !st_q.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{active: 1'b0, kind: OP_PROGRAM, wdata: '0};
        end else if (start_o) begin
            st_q.active <= 1'b1;
            st_q.kind   <= op_kind_e'(kind_i);
            st_q.wdata  <= wdata_i;
        end else if (!busy_i) begin
            st_q.active <= 1'b0;
        end
    end

    assign state_o = st_q;

    // R7
    active_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.active) |-> $past(busy_i));

    // R2
    wdata_held_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && busy_i) |=> $stable(st_q.wdata) && $stable(st_q.kind));

endmodule

// File: rtl/fsr_read_edge.sv
module fsr_read_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic rise_o
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_i;
    end

    assign rise_o = strobe_i && !strobe_q;

endmodule

// File: rtl/fsr_toggle_bit.sv
module fsr_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic step_i,
    output logic tog_o
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) tog_q <= 1'b0;
        else if (step_i)    tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;

    // R9
    toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (tog_q == 1'b0));

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clear_i) |=> (tog_q != $past(tog_q)));

    // R8
    toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !clear_i) |=> $stable(tog_q));

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import flash_stat_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] last_data_i,
    input  logic              rd_strobe_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    op_state_t op_st;
    logic      op_start;
    logic      rd_rise;
    logic      tog;
    logic      step;
    logic      pflag;

    fsr_op_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy_i),
        .kind_i  (op_erase_i),
        .wdata_i (last_data_i),
        .state_o (op_st),
        .start_o (op_start)
    );

    fsr_read_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (rd_strobe_i),
        .rise_o   (rd_rise)
    );

    assign step = rd_rise && op_st.active;

    fsr_toggle_bit u_tog (
        .clk     (clk),
        .rst     (rst),
        .clear_i (op_start),
        .step_i  (step),
        .tog_o   (tog)
    );

    assign pflag = poll_flag(op_st);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_POS) begin : g_poll
            assign rd_data_o[b] = op_st.active ? pflag : array_data_i[b];
        end else if (b == TOGGLE_POS) begin : g_tog
            assign rd_data_o[b] = op_st.active ? tog : array_data_i[b];
        end else begin : g_zero
            assign rd_data_o[b] = op_st.active ? 1'b0 : array_data_i[b];
        end
    end

    // R5
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        op_st.active |-> (rd_data_o[5:0] == '0));

    // R3
    erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (op_st.active && op_st.kind == OP_ERASE) |-> !rd_data_o[POLL_POS]);

    // R6
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !op_st.active |-> (rd_data_o == array_data_i));

endmodule

// File: tb/flash_busy_status_test.sv
module flash_busy_status_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       busy;
    logic       kind;
    logic [7:0] wdata;
    logic       strobe;
    logic [7:0] arr;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic       cur_kind;
    logic [7:0] cur_data;
    logic       exp_tog;

    always #2 clk = ~clk;

    flash_busy_status uut (
        .clk          (clk),
        .rst          (rst),
        .busy_i       (busy),
        .op_erase_i   (kind),
        .last_data_i  (wdata),
        .rd_strobe_i  (strobe),
        .array_data_i (arr),
        .rd_data_o    (dout)
    );

    function automatic logic [7:0] exp_status(logic erase, logic [7:0] d, logic t);
        logic p;
        p = erase ? 1'b0 : ~d[7];
        return {p, t, 6'b0};
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic start_op(logic k, logic [7:0] d);
        @(negedge clk);
        busy = 1'b1; kind = k; wdata = d;
        #1 chk("R7 status not before edge", dout, arr);
        @(negedge clk);
        cur_kind = k; cur_data = d; exp_tog = 1'b0;
        chk("R9 toggle cleared at start", dout, exp_status(k, d, 1'b0));
        wdata = ~d;   // must be ignored (R2)
        kind  = ~k;
    endtask

    task automatic busy_read(int hold);
        @(negedge clk);
        strobe = 1'b1; arr = 8'($urandom);
        @(negedge clk);
        exp_tog = ~exp_tog;
        chk(cur_kind ? "R3 R4 R5 erase read" : "R2 R4 R5 program read",
            dout, exp_status(cur_kind, cur_data, exp_tog));
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk("R8 held strobe single read", dout, exp_status(cur_kind, cur_data, exp_tog));
        end
        strobe = 1'b0;
    endtask

    task automatic end_op(logic [7:0] a);
        @(negedge clk);
        busy = 1'b0; arr = a;
        #1 chk("R7 status held until edge", dout, exp_status(cur_kind, cur_data, exp_tog));
        @(negedge clk);
        chk("R6 array data after completion", dout, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; busy = 1'b0; kind = 1'b0; wdata = 8'h00; strobe = 1'b0; arr = 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset passes array data", dout, 8'h5A);
        arr = 8'hC3;
        #1 chk("R1 idle passthrough", dout, 8'hC3);

        // Directed: program with bit7 = 1, first read toggle = 1
        start_op(1'b0, 8'h80);
        busy_read(1);
        chk("R4 first read toggle is 1", {7'b0, dout[6]}, 8'h01);
        busy_read(1);
        busy_read(3);
        end_op(8'h80);

        // Directed: erase, completes to FFh
        start_op(1'b1, 8'h12);
        busy_read(2);
        chk("R3 erase poll bit zero", {7'b0, dout[7]}, 8'h00);
        end_op(8'hFF);
        chk("R6 erased reads bit7 one", {7'b0, dout[7]}, 8'h01);

        // Directed: new op after odd read count resets toggle
        start_op(1'b0, 8'h00);
        busy_read(1);
        end_op(8'h33);
        start_op(1'b0, 8'h7F);
        busy_read(1);
        end_op(8'h44);

        // Idle reads don't alter status of later op
        @(negedge clk); strobe = 1'b1; arr = 8'h9D;
        @(negedge clk); chk("R6 idle read passthrough", dout, 8'h9D);
        strobe = 1'b0;

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic       k;
            logic [7:0] d;
            int         reads;
            k = 1'($urandom);
            d = 8'($urandom);
            reads = 1 + int'($urandom % 6);
            start_op(k, d);
            for (int r = 0; r < reads; r++) begin
                busy_read(1 + int'($urandom % 3));
                repeat (int'($urandom % 2)) @(negedge clk);
            end
            end_op(k ? 8'hFF : d);
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule